// File: doc/BRIEF.md
# Shared Debug Status Arbiter

This block keeps a bank of debug status bits and a matching bank of per-resource control bits, and divides ownership of every debug resource between on-chip software and an external debug port. An allocation register, which only the external port can write, marks each resource as software-owned or hardware-owned. Ownership decides whether an event may set a status bit, what software sees when it reads the status register, and which fields a software write may change. It also decides whether a set bit may contribute to the debug interrupt request.

Software reaches the registers through a special-register read/write port with limited rights. The external debug port has full access and always sees and writes the true contents. Three mode inputs come from the surrounding core: an interrupt-enable flag, an internal (software) debug mode and an external (hardware) debug mode. Event pulses come from detection logic outside the block. The block drives one level-sensitive interrupt request.

Both ports use the same register addresses: 0 is status, 1 is control and 2 is allocation. In the allocation register, bits [NUM_RES-1:0] give the owners and bit 31 is the software-hide flag. Status and control sit in bits [NUM_RES-1:0] and read as zero above those bits.

Top module: `dbg_share_arb`

## Requirements
- R1: An event pulse on a software-owned resource (allocation bit i = 1) sets status bit i at the next clock edge only while int_mode is 1. Otherwise it leaves the bit unchanged.
- R2: An event pulse on a hardware-owned resource (allocation bit i = 0) sets status bit i at the next clock edge only while ext_mode is 1. Otherwise it leaves the bit unchanged.
- R3: irq is 1 exactly when de_en = 1, int_mode = 1, and either ext_mode = 0 or at least one resource is software-owned, and some software-owned, interrupt-capable status bit is 1.
- R4: Status bits 0 and 1 (the reset-record bit and the second excluded bit, set by NOINT_MASK = 16'h0003) never cause irq, even when they are software-owned.
- R5: When allocation bit 31 (hide flag) is 1, a software read of status (address 0) returns 0 in every bit whose resource is hardware-owned. When the flag is 0, software reads the true status.
- R6: The debug port reads and writes the true, unmasked contents of status (address 0), control (address 1) and allocation (address 2). A debug write to status loads the written value directly.
- R7: A software write to status is write-one-to-clear, and it affects only software-owned bits. A software write to control loads only the software-owned bits. Hardware-owned bits keep their value.
- R8: The allocation register is read-only to software: a software write to address 2 changes nothing. Only the debug port can write it.
- R9: Power-on reset (por) clears all three registers. tap_tlr clears only the allocation register. System reset (rst) clears status and control but leaves allocation unchanged.
- R10: When an event set and a software clear hit the same status bit in one cycle, the bit ends at 1. When both ports write the control register in one cycle, the debug port's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| por | input | 1 | Synchronous power-on reset, active high |
| tap_tlr | input | 1 | Debug TAP is in Test-Logic-Reset; clears allocation |
| de_en | input | 1 | Debug interrupt enable from machine state |
| int_mode | input | 1 | Internal (software) debug mode enabled |
| ext_mode | input | 1 | External (hardware) debug mode enabled |
| evt | input | NUM_RES | One-cycle event pulses, one per resource |
| sw_wr | input | 1 | Software write strobe |
| sw_addr | input | 2 | Software register address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data (masked view) |
| dbg_wr | input | 1 | Debug port write strobe |
| dbg_addr | input | 2 | Debug port register address |
| dbg_wdata | input | 32 | Debug port write data |
| dbg_rdata | output | 32 | Debug port read data (true view) |
| irq | output | 1 | Debug interrupt request |

## Verification
An event that sets a status bit can land in the same cycle as a software write-one-to-clear of that same bit. The bench provokes this by preloading bits 3 and 4 through the debug port, pulsing an event on bit 3 and writing ones to bits 3 and 4 from software in the same cycle. It then expects bit 3 to survive and bit 4 to clear. It also has both ports write the control register in one cycle and expects the debug port's value to be kept.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        RA_STAT  = 2'd0,
        RA_CTRL  = 2'd1,
        RA_ALLOC = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic      we;
        reg_addr_e addr;
        logic [DW-1:0] wdata;
    } reg_req_t;

    function automatic reg_req_t mk_req(input logic we, input logic [1:0] addr,
                                        input logic [DW-1:0] wdata);
        reg_req_t r;
        r.we    = we;
        r.addr  = reg_addr_e'(addr);
        r.wdata = wdata;
        return r;
    endfunction

    function automatic logic hits(input reg_req_t r, input reg_addr_e a);
        return r.we && (r.addr == a);
    endfunction

endpackage

// File: rtl/dbg_owner_reg.sv
module dbg_owner_reg
    import dbg_arb_pkg::*;
(
    input  logic          clk,
    input  logic          por,
    input  logic          tap_tlr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk) begin
        if (por || tap_tlr)
            q <= '0;
        else if (we)
            q <= wdata;
    end

    // R9
    alloc_clear_chk: assert property (@(posedge clk)
        (por || tap_tlr) |=> (q == '0));

    // R8
    alloc_hold_chk: assert property (@(posedge clk) disable iff (por || tap_tlr)
        !we |=> $stable(q));

endmodule

// File: rtl/dbg_stat_bit.sv
module dbg_stat_bit (
    input  logic clk,
    input  logic clr,
    input  logic evt,
    input  logic own,
    input  logic int_mode,
    input  logic ext_mode,
    input  logic hw_stat_we,
    input  logic hw_stat_d,
    input  logic sw_stat_we,
    input  logic sw_stat_d,
    input  logic hw_ctrl_we,
    input  logic hw_ctrl_d,
    input  logic sw_ctrl_we,
    input  logic sw_ctrl_d,
    output logic stat_q,
    output logic ctrl_q
);

    logic set_ok, sw_clr, stat_d, ctrl_d;

    always_comb begin
        set_ok = evt && (own ? int_mode : ext_mode);
        sw_clr = sw_stat_we && own && sw_stat_d;
        if (set_ok)
            stat_d = 1'b1;
        else if (hw_stat_we)
            stat_d = hw_stat_d;
        else if (sw_clr)
            stat_d = 1'b0;
        else
            stat_d = stat_q;

        if (hw_ctrl_we)
            ctrl_d = hw_ctrl_d;
        else if (sw_ctrl_we && own)
            ctrl_d = sw_ctrl_d;
        else
            ctrl_d = ctrl_q;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            stat_q <= 1'b0;
            ctrl_q <= 1'b0;
        end else begin
            stat_q <= stat_d;
            ctrl_q <= ctrl_d;
        end
    end

    // R1 R10
    sw_evt_set_chk: assert property (@(posedge clk) disable iff (clr)
        (evt && own && int_mode) |=> stat_q);

    // R2
    hw_evt_gate_chk: assert property (@(posedge clk) disable iff (clr)
        (evt && !own && !ext_mode && !hw_stat_we && !stat_q) |=> !stat_q);

    // R7
    hw_owned_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (!own && !evt && !hw_stat_we && !hw_ctrl_we) |=> ($stable(stat_q) && $stable(ctrl_q)));

endmodule

// File: rtl/dbg_irq_gen.sv
module dbg_irq_gen #(
    parameter int                 NUM_RES    = 16,
    parameter logic [NUM_RES-1:0] NOINT_MASK = 16'h0003
) (
    input  logic [NUM_RES-1:0] stat,
    input  logic [NUM_RES-1:0] own,
    input  logic               de_en,
    input  logic               int_mode,
    input  logic               ext_mode,
    output logic               irq
);

    logic allowed, pending;

    always_comb begin
        allowed = de_en && int_mode && (!ext_mode || (|own));
        pending = |(stat & own & ~NOINT_MASK);
        irq     = allowed && pending;
    end

endmodule

// File: rtl/dbg_share_arb.sv
module dbg_share_arb
    import dbg_arb_pkg::*;
#(
    parameter int                 NUM_RES    = 16,
    parameter logic [NUM_RES-1:0] NOINT_MASK = 16'h0003
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               por,
    input  logic               tap_tlr,
    input  logic               de_en,
    input  logic               int_mode,
    input  logic               ext_mode,
    input  logic [NUM_RES-1:0] evt,
    input  logic               sw_wr,
    input  logic [1:0]         sw_addr,
    input  logic [DW-1:0]      sw_wdata,
    output logic [DW-1:0]      sw_rdata,
    input  logic               dbg_wr,
    input  logic [1:0]         dbg_addr,
    input  logic [DW-1:0]      dbg_wdata,
    output logic [DW-1:0]      dbg_rdata,
    output logic               irq
);

    // NUM_RES must stay below DW so the hide flag has its own bit.
    localparam int PAD      = DW - NUM_RES;
    localparam int HIDE_BIT = DW - 1;

    reg_req_t sw_req, hw_req;
    logic [DW-1:0]      alloc_q;
    logic [NUM_RES-1:0] own, stat_q, ctrl_q, view_mask;
    logic               hide, bank_clr;
    logic               unused_sw;

    assign sw_req    = mk_req(sw_wr, sw_addr, sw_wdata);
    assign hw_req    = mk_req(dbg_wr, dbg_addr, dbg_wdata);
    assign own       = alloc_q[NUM_RES-1:0];
    assign hide      = alloc_q[HIDE_BIT];
    assign bank_clr  = rst || por;
    assign unused_sw = ^sw_wdata[DW-1:NUM_RES];

    dbg_owner_reg u_owner (
        .clk     (clk),
        .por     (por),
        .tap_tlr (tap_tlr),
        .we      (hits(hw_req, RA_ALLOC)),
        .wdata   (hw_req.wdata),
        .q       (alloc_q)
    );

    for (genvar i = 0; i < NUM_RES; i++) begin : g_res
        dbg_stat_bit u_bit (
            .clk        (clk),
            .clr        (bank_clr),
            .evt        (evt[i]),
            .own        (own[i]),
            .int_mode   (int_mode),
            .ext_mode   (ext_mode),
            .hw_stat_we (hits(hw_req, RA_STAT)),
            .hw_stat_d  (hw_req.wdata[i]),
            .sw_stat_we (hits(sw_req, RA_STAT)),
            .sw_stat_d  (sw_req.wdata[i]),
            .hw_ctrl_we (hits(hw_req, RA_CTRL)),
            .hw_ctrl_d  (hw_req.wdata[i]),
            .sw_ctrl_we (hits(sw_req, RA_CTRL)),
            .sw_ctrl_d  (sw_req.wdata[i]),
            .stat_q     (stat_q[i]),
            .ctrl_q     (ctrl_q[i])
        );
    end

    dbg_irq_gen #(
        .NUM_RES    (NUM_RES),
        .NOINT_MASK (NOINT_MASK)
    ) u_irq (
        .stat     (stat_q),
        .own      (own),
        .de_en    (de_en),
        .int_mode (int_mode),
        .ext_mode (ext_mode),
        .irq      (irq)
    );

    assign view_mask = hide ? own : '1;

    always_comb begin
        unique case (sw_req.addr)
            RA_STAT:  sw_rdata = {{PAD{1'b0}}, stat_q & view_mask};
            RA_CTRL:  sw_rdata = {{PAD{1'b0}}, ctrl_q};
            RA_ALLOC: sw_rdata = alloc_q;
            default:  sw_rdata = '0;
        endcase
        unique case (hw_req.addr)
            RA_STAT:  dbg_rdata = {{PAD{1'b0}}, stat_q};
            RA_CTRL:  dbg_rdata = {{PAD{1'b0}}, ctrl_q};
            RA_ALLOC: dbg_rdata = alloc_q;
            default:  dbg_rdata = '0;
        endcase
    end

    // R3
    irq_gate_chk: assert property (@(posedge clk) disable iff (bank_clr)
        irq |-> (de_en && int_mode && (|(stat_q & own))));

    // R4
    irq_noint_chk: assert property (@(posedge clk) disable iff (bank_clr)
        ((stat_q & ~NOINT_MASK) == '0) |-> !irq);

    // R5
    hide_mask_chk: assert property (@(posedge clk) disable iff (bank_clr)
        (hide && sw_addr == RA_STAT) |-> ((sw_rdata[NUM_RES-1:0] & ~own) == '0));

    // R6
    dbg_load_chk: assert property (@(posedge clk) disable iff (bank_clr)
        (dbg_wr && dbg_addr == RA_CTRL) |=> (ctrl_q == $past(dbg_wdata[NUM_RES-1:0])));

endmodule

// File: tb/sim_dbg_share_arb.sv
module sim_dbg_share_arb;
    import dbg_arb_pkg::*;

    localparam int N = 16;

    logic clk = 1'b0;
    logic rst, por, tap_tlr, de_en, int_mode, ext_mode;
    logic [N-1:0] evt;
    logic sw_wr, dbg_wr;
    logic [1:0] sw_addr, dbg_addr;
    logic [DW-1:0] sw_wdata, dbg_wdata, sw_rdata, dbg_rdata;
    logic irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbg_share_arb u0 (
        .clk(clk), .rst(rst), .por(por), .tap_tlr(tap_tlr), .de_en(de_en),
        .int_mode(int_mode), .ext_mode(ext_mode), .evt(evt),
        .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .dbg_wr(dbg_wr), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .irq(irq)
    );

    typedef struct packed {
        logic [N-1:0] own;
        logic         im;
        logic         em;
        logic [N-1:0] ev;
        logic [N-1:0] exp;
    } vec_t;

    localparam vec_t VT [6] = '{
        '{16'h00FF, 1'b1, 1'b0, 16'hFFFF, 16'h00FF},
        '{16'h00FF, 1'b0, 1'b1, 16'hFFFF, 16'hFF00},
        '{16'h00FF, 1'b1, 1'b1, 16'h0F0F, 16'h0F0F},
        '{16'h0000, 1'b1, 1'b0, 16'hFFFF, 16'h0000},
        '{16'hFFFF, 1'b0, 1'b0, 16'hFFFF, 16'h0000},
        '{16'hF0F0, 1'b1, 1'b1, 16'h1234, 16'h1234}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic dwr(input logic [1:0] a, input logic [DW-1:0] d);
        dbg_addr = a; dbg_wdata = d; dbg_wr = 1'b1;
        step();
        dbg_wr = 1'b0;
    endtask

    task automatic swr(input logic [1:0] a, input logic [DW-1:0] d);
        sw_addr = a; sw_wdata = d; sw_wr = 1'b1;
        step();
        sw_wr = 1'b0;
    endtask

    task automatic drd(input logic [1:0] a, output logic [DW-1:0] d);
        dbg_addr = a; #1; d = dbg_rdata;
    endtask

    task automatic srd(input logic [1:0] a, output logic [DW-1:0] d);
        sw_addr = a; #1; d = sw_rdata;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r;
        rst = 1'b1; por = 1'b1; tap_tlr = 1'b0; de_en = 1'b0;
        int_mode = 1'b0; ext_mode = 1'b0; evt = '0;
        sw_wr = 1'b0; sw_addr = 2'd0; sw_wdata = '0;
        dbg_wr = 1'b0; dbg_addr = 2'd0; dbg_wdata = '0;
        step(); step();
        rst = 1'b0; por = 1'b0;

        // R9 reset state
        drd(2'd0, r); check("R9 reset status", r, 0);
        drd(2'd1, r); check("R9 reset control", r, 0);
        drd(2'd2, r); check("R9 reset alloc", r, 0);
        check("R3 reset irq", {31'd0, irq}, 0);

        // R1 R2 table of event gating
        foreach (VT[k]) begin
            dwr(2'd0, 0);
            dwr(2'd2, {16'd0, VT[k].own});
            int_mode = VT[k].im; ext_mode = VT[k].em; evt = VT[k].ev;
            step();
            evt = '0; int_mode = 1'b0; ext_mode = 1'b0;
            drd(2'd0, r);
            check($sformatf("R1 R2 vector %0d", k), r, {16'd0, VT[k].exp});
        end

        // R8 software cannot write allocation
        dwr(2'd2, 32'h0000_00FF);
        swr(2'd2, 32'hFFFF_FFFF);
        drd(2'd2, r); check("R8 alloc read-only", r, 32'h0000_00FF);
        srd(2'd2, r); check("R8 sw reads alloc", r, 32'h0000_00FF);

        // R5 R6 hide flag and true debug view
        dwr(2'd0, 32'h0000_FFFF);
        srd(2'd0, r); check("R5 hide off", r, 32'h0000_FFFF);
        dwr(2'd2, 32'h8000_00FF);
        srd(2'd0, r); check("R5 hide on", r, 32'h0000_00FF);
        drd(2'd0, r); check("R6 debug true status", r, 32'h0000_FFFF);

        // R7 software write-one-to-clear on owned bits only
        swr(2'd0, 32'h0000_FFFF);
        drd(2'd0, r); check("R7 w1c owned only", r, 32'h0000_FF00);
        swr(2'd1, 32'h0000_FFFF);
        drd(2'd1, r); check("R7 ctrl owned only", r, 32'h0000_00FF);
        dwr(2'd1, 32'h0000_A5A5);
        drd(2'd1, r); check("R6 debug ctrl write", r, 32'h0000_A5A5);

        // R10 set beats clear, debug beats software
        dwr(2'd2, 32'h0000_00FF);
        dwr(2'd0, 32'h0000_0018);
        int_mode = 1'b1; evt = 16'h0008;
        sw_addr = 2'd0; sw_wdata = 32'h0000_0018; sw_wr = 1'b1;
        step();
        sw_wr = 1'b0; evt = '0; int_mode = 1'b0;
        drd(2'd0, r); check("R10 set wins over clear", r, 32'h0000_0008);
        sw_addr = 2'd1; sw_wdata = 32'h0000_00FF; sw_wr = 1'b1;
        dbg_addr = 2'd1; dbg_wdata = 32'h0000_0000; dbg_wr = 1'b1;
        step();
        sw_wr = 1'b0; dbg_wr = 1'b0;
        drd(2'd1, r); check("R10 debug ctrl wins", r, 0);

        // R3 R4 interrupt request
        de_en = 1'b1; int_mode = 1'b1; ext_mode = 1'b0;
        dwr(2'd0, 32'h0000_0003); #1;
        check("R4 excluded bits no irq", {31'd0, irq}, 0);
        dwr(2'd0, 32'h0000_0004); #1;
        check("R3 irq raised", {31'd0, irq}, 1);
        ext_mode = 1'b1; #1;
        check("R3 irq with ext and sw owner", {31'd0, irq}, 1);
        de_en = 1'b0; #1;
        check("R3 irq needs de_en", {31'd0, irq}, 0);
        de_en = 1'b1; int_mode = 1'b0; #1;
        check("R3 irq needs int_mode", {31'd0, irq}, 0);
        int_mode = 1'b1;
        dwr(2'd0, 32'h0000_0100); #1;
        check("R3 hw-owned bit no irq", {31'd0, irq}, 0);
        dwr(2'd2, 32'h0000_0000);
        dwr(2'd0, 32'h0000_0004); #1;
        check("R3 ext with no sw owner", {31'd0, irq}, 0);
        de_en = 1'b0; int_mode = 1'b0; ext_mode = 1'b0;

        // R9 reset domains
        dwr(2'd2, 32'h0000_00FF);
        dwr(2'd1, 32'h0000_0F0F);
        rst = 1'b1; step(); rst = 1'b0;
        drd(2'd2, r); check("R9 rst keeps alloc", r, 32'h0000_00FF);
        drd(2'd1, r); check("R9 rst clears ctrl", r, 0);
        dwr(2'd0, 32'h0000_0055);
        tap_tlr = 1'b1; step(); tap_tlr = 1'b0;
        drd(2'd2, r); check("R9 tlr clears alloc", r, 0);
        drd(2'd0, r); check("R9 tlr keeps status", r, 32'h0000_0055);
        dwr(2'd2, 32'h0000_00FF);
        por = 1'b1; step(); por = 1'b0;
        drd(2'd2, r); check("R9 por clears alloc", r, 0);
        drd(2'd0, r); check("R9 por clears status", r, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule